// File: doc/BRIEF.md
# Third-Order Bitstream Decimation Filter

This block converts the one-bit output of a second-order delta-sigma modulator into signed multi-bit samples at a reduced rate. It is a cascaded integrator-comb filter of order three: three running-sum stages clocked by the modulator clock (one input bit per clock), a down-sampler, and three difference stages that run only when a result is taken. The overall response is the third power of a length-OSR moving sum.

The oversampling ratio is chosen at run time as a power of two, from 16 to 256, through a small exponent input. A change of ratio, like a reset, clears the filter and restarts both the decimation phase and the settling count. Each result is scaled to a signed 16-bit code in which half ones maps to zero. It comes with a one-cycle valid pulse and a flag that marks results whose whole filter window lies after the last restart.

Top module: `sinc3_decimator`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as -1, so a settled stream with exactly half ones yields the result 0.
- R2: For a periodic input whose period divides the ratio, every settled result equals floor((2p-1)·32768) as a two's-complement 16-bit word, where p is the fraction of ones (75 % gives 16384, 25 % gives -16384, 87.5 % gives 24576).
- R3: `valid_o` is a single-cycle pulse, and successive pulses are exactly 2^k clock cycles apart, where k is the effective ratio exponent. The result rate is the clock rate divided by the ratio.
- R4: Results saturate: an all-ones stream yields 32767 and an all-zeros stream yields -32768.
- R5: The first three results after a reset or a ratio restart carry `settled_o` = 0. The fourth and every later result carry `settled_o` = 1. `settled_o` is never 1 without `valid_o`.
- R6: A change of the effective ratio clears the filter state and the decimation phase. No result is presented in the cycle after the change.
- R7: `osr_sel` (4 bits) holds the ratio exponent and is limited to 4..8: values below 4 act as 4 and values above 8 act as 8. A new value that limits to the current exponent causes no restart.
- R8: While `rst_n` is low, `valid_o`, `settled_o` and `data_o` are all 0.
- R9: Internal sums wrap in two's complement without harm: a long all-ones run at ratio 256, during which the running sums overflow, keeps returning 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; one bitstream sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| osr_sel | input | 4 | Ratio exponent k, ratio = 2^k, limited to 4..8 |
| bit_i | input | 1 | Modulator output bit |
| data_o | output | 16 | Signed filtered result, held between pulses |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| settled_o | output | 1 | High with valid_o once the filter window is free of pre-restart state |

## Verification
Counting from the first clock edge after a restart as cycle 0, a result is taken in cycle n·2^k − 1 and appears on the outputs one cycle later. The first settled result is therefore the fourth pulse, about 4·2^k cycles after the restart. The bench never predicts an absolute cycle. It samples on falling edges, waits for each valid pulse, and counts pulses and the falling edges between them, so the position of the first settled result and the pulse spacing are both measured against what the requirements predict. The cycle after a ratio change is sampled directly to confirm that no result appears.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   // Limit an integer to the closed range [lo, hi].
   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
   parameter int LOG2_MIN = 4,
   parameter int LOG2_MAX = 8,
   parameter int ORDER    = 3,
   parameter int SEL_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] osr_sel,
   output logic [SEL_W-1:0] osr_q,
   output logic             restart,
   output logic             strobe,
   output logic             settle_full
);
   localparam int CNT_W = LOG2_MAX;
   localparam int RAT_W = LOG2_MAX + 1;
   localparam int SET_W = $clog2(ORDER + 1);

   logic [SEL_W-1:0] sel_lim;
   logic [RAT_W-1:0] ratio;
   logic [CNT_W-1:0] last_idx;
   logic [CNT_W-1:0] cnt;
   logic [SET_W-1:0] settle_cnt;

   always_comb begin
      sel_lim  = SEL_W'(sinc3_pkg::clamp_int(int'(osr_sel), LOG2_MIN, LOG2_MAX));
      ratio    = RAT_W'(1) << osr_q;
      last_idx = CNT_W'(ratio - RAT_W'(1));
   end

   assign restart     = rst_n && (sel_lim != osr_q);
   assign strobe      = rst_n && !restart && (cnt == last_idx);
   assign settle_full = (settle_cnt == SET_W'(ORDER));

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         osr_q      <= sel_lim;
         cnt        <= '0;
         settle_cnt <= '0;
      end else if (strobe) begin
         cnt <= '0;
         if (!settle_full) settle_cnt <= settle_cnt + SET_W'(1);
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (osr_q >= SEL_W'(LOG2_MIN)) && (osr_q <= SEL_W'(LOG2_MAX))); // R7

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int W     = 26,
   parameter int ORDER = 3
) (
   input  logic         clk,
   input  logic         clear,
   input  logic         bit_i,
   output logic [W-1:0] acc_o
);
   logic [W-1:0] st_in [ORDER];
   logic [W-1:0] st_q  [ORDER];

   for (genvar j = 0; j < ORDER; j++) begin : g_stage
      if (j == 0) begin : g_first
         // bit 1 -> +1, bit 0 -> -1 (all ones in two's complement)
         assign st_in[j] = bit_i ? W'(1) : {W{1'b1}};
      end else begin : g_next
         assign st_in[j] = st_q[j-1];
      end

      always_ff @(posedge clk) begin
         if (clear) st_q[j] <= '0;
         else       st_q[j] <= st_q[j] + st_in[j];
      end
   end

   assign acc_o = st_q[ORDER-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int W     = 26,
   parameter int ORDER = 3
) (
   input  logic         clk,
   input  logic         clear,
   input  logic         strobe,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] st  [ORDER+1];
   logic [W-1:0] dly [ORDER];

   assign st[0] = din;

   for (genvar j = 0; j < ORDER; j++) begin : g_stage
      assign st[j+1] = st[j] - dly[j];

      always_ff @(posedge clk) begin
         if (clear)       dly[j] <= '0;
         else if (strobe) dly[j] <= st[j];
      end
   end

   assign dout = st[ORDER];

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
   parameter int W       = 26,
   parameter int OUT_W   = 16,
   parameter int SHIFT_W = 5
) (
   input  logic [W-1:0]       y,
   input  logic [SHIFT_W-1:0] shift,
   output logic [OUT_W-1:0]   sat
);
   localparam int EW = W + OUT_W - 1;
   localparam logic signed [EW-1:0] HI = {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [EW-1:0] LO = {{(EW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [EW-1:0] ext;

   always_comb begin
      ext = $signed({y, {(OUT_W-1){1'b0}}}) >>> shift;
      if (ext > HI)      sat = HI[OUT_W-1:0];
      else if (ext < LO) sat = LO[OUT_W-1:0];
      else               sat = ext[OUT_W-1:0];
   end

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
   parameter int OUT_W    = 16,
   parameter int LOG2_MIN = 4,
   parameter int LOG2_MAX = 8,
   parameter int ORDER    = 3,
   parameter int SEL_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] osr_sel,
   input  logic             bit_i,
   output logic [OUT_W-1:0] data_o,
   output logic             valid_o,
   output logic             settled_o
);
   localparam int W       = 2 + ORDER * LOG2_MAX;
   localparam int SHIFT_W = $clog2(ORDER * LOG2_MAX + 1);
   localparam int RAT_W   = LOG2_MAX + 1;
   localparam int VC_W    = $clog2(ORDER + 1);

   logic [SEL_W-1:0]   osr_q;
   logic               restart, strobe, settle_full, clear;
   logic [W-1:0]       acc, comb_out;
   logic [SHIFT_W-1:0] shift_amt;
   logic [OUT_W-1:0]   scaled;

   assign clear     = !rst_n || restart;
   assign shift_amt = SHIFT_W'(ORDER * int'(osr_q));

   sinc3_ctrl #(.LOG2_MIN(LOG2_MIN), .LOG2_MAX(LOG2_MAX), .ORDER(ORDER), .SEL_W(SEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .osr_sel(osr_sel), .osr_q(osr_q),
      .restart(restart), .strobe(strobe), .settle_full(settle_full));

   sinc3_integ #(.W(W), .ORDER(ORDER)) u_integ (
      .clk(clk), .clear(clear), .bit_i(bit_i), .acc_o(acc));

   sinc3_comb #(.W(W), .ORDER(ORDER)) u_comb (
      .clk(clk), .clear(clear), .strobe(strobe), .din(acc), .dout(comb_out));

   sinc3_scale #(.W(W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_scale (
      .y(comb_out), .shift(shift_amt), .sat(scaled));

   always_ff @(posedge clk) begin
      if (clear) begin
         data_o    <= '0;
         valid_o   <= 1'b0;
         settled_o <= 1'b0;
      end else begin
         valid_o   <= strobe;
         settled_o <= strobe && settle_full;
         if (strobe) data_o <= scaled;
      end
   end

   // Independent observers of the output side
   logic [RAT_W-1:0] gap;
   logic             seen;
   logic [VC_W-1:0]  vcount;

   always_ff @(posedge clk) begin
      if (clear) begin
         gap    <= '0;
         seen   <= 1'b0;
         vcount <= '0;
      end else begin
         if (valid_o) begin
            gap  <= RAT_W'(1);
            seen <= 1'b1;
            if (vcount != VC_W'(ORDER)) vcount <= vcount + VC_W'(1);
         end else begin
            gap <= gap + RAT_W'(1);
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R3
   AST_OUTPUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && seen) |-> (gap == (RAT_W'(1) << osr_q))); // R3
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!valid_o && !settled_o)); // R6
   AST_SETTLED_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      settled_o |-> valid_o); // R5
   AST_SETTLED_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      settled_o |-> (vcount == VC_W'(ORDER))); // R5
   AST_SETTLED_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && vcount == VC_W'(ORDER)) |-> settled_o); // R5

endmodule

// File: tb/sinc3_decimator_tb.sv
module sinc3_decimator_tb;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bit_i = 1'b0;
   logic [3:0]         osr_sel = 4'd4;
   logic signed [15:0] data_o;
   logic               valid_o, settled_o;

   int checks = 0;
   int fails  = 0;
   int pat_period = 2;
   int pat_ones   = 1;
   int phase      = 0;

   // osr[31:28] period[27:22] ones[21:16] expected[15:0]
   localparam logic [31:0] VEC [8] = '{
      {4'd4, 6'd2,  6'd1,  16'h0000},
      {4'd4, 6'd4,  6'd3,  16'h4000},
      {4'd5, 6'd4,  6'd1,  16'hC000},
      {4'd6, 6'd8,  6'd7,  16'h6000},
      {4'd7, 6'd16, 6'd11, 16'h3000},
      {4'd5, 6'd8,  6'd1,  16'hA000},
      {4'd8, 6'd1,  6'd1,  16'h7FFF},
      {4'd8, 6'd1,  6'd0,  16'h8000}
   };

   always #5 clk = ~clk;

   sinc3_decimator u_dut (
      .clk(clk), .rst_n(rst_n), .osr_sel(osr_sel), .bit_i(bit_i),
      .data_o(data_o), .valid_o(valid_o), .settled_o(settled_o));

   // Periodic modulator model: 'pat_ones' ones followed by zeros, period 'pat_period'
   always @(negedge clk) begin
      bit_i <= (phase < pat_ones);
      phase <= (phase + 1) % pat_period;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_valid(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!valid_o && cyc < 3000);
      if (!valid_o) cyc = -1;
   endtask

   task automatic set_pattern(input int per, input int ones);
      @(negedge clk);
      pat_period = per;
      pat_ones   = ones;
      phase      = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", "valid in reset", int'(valid_o), 0);
      check("R8", "settled in reset", int'(settled_o), 0);
      check("R8", "data in reset", int'(data_o), 0);
      rst_n = 1'b1;
   endtask

   // Wait for the first settled result, check its position, value and the next spacing
   task automatic settle_check(input string req, input int exp, input int k);
      int n = 0;
      int c;
      while (n < 8) begin
         wait_valid(c);
         if (c < 0) break;
         n++;
         if (settled_o) break;
      end
      check("R5", "pulses until settled", n, 4);
      check(req, "settled value", int'(data_o), exp);
      wait_valid(c);
      check("R3", "pulse spacing", c, 1 << k);
   endtask

   initial begin
      int c;
      for (int i = 0; i < 8; i++) begin
         int exp;
         string tag;
         exp = int'($signed(VEC[i][15:0]));
         tag = (exp == 0) ? "R1" : ((exp == 32767 || exp == -32768) ? "R4" : "R2");
         set_pattern(int'(VEC[i][27:22]), int'(VEC[i][21:16]));
         osr_sel = VEC[i][31:28];
         do_reset();
         settle_check(tag, exp, int'(VEC[i][31:28]));
         if (VEC[i][31:28] == 4'd8 && VEC[i][27:22] == VEC[i][21:16]) begin
            // R9: running sums have wrapped by now; results must stay at full scale
            for (int r = 0; r < 3; r++) begin
               wait_valid(c);
               check("R9", "wrapped sums value", int'(data_o), 32767);
            end
         end
      end

      // R7: exponent below range acts as 4
      set_pattern(4, 3);
      osr_sel = 4'd2;
      do_reset();
      settle_check("R7", 16384, 4);

      // R7: exponent above range acts as 8
      set_pattern(4, 1);
      osr_sel = 4'd15;
      do_reset();
      settle_check("R7", -16384, 8);

      // R7: a new value that limits to the same exponent does not restart
      osr_sel = 4'd9;
      wait_valid(c);
      check("R7", "spacing after equivalent change", c, 256);
      check("R7", "settled kept", int'(settled_o), 1);

      // R6: ratio change restarts the filter
      @(negedge clk);
      osr_sel = 4'd4;
      @(negedge clk);
      check("R6", "valid after ratio change", int'(valid_o), 0);
      settle_check("R6", -16384, 4);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule